// File: doc/BRIEF.md
# Sliced Preloadable Clock Divider

This block divides its input clock with a 12-bit synchronous up-counter. The counter is made of three 4-bit slices. Each slice counts only when its carry-in is high. It raises its carry-out when that carry-in is high and all four of its bits are ones. The carry-out of each slice feeds the carry-in of the slice above it, so the three slices step together as one 12-bit counter.

When the top slice's carry-out rises, the counter sits at all ones. That carry-out, inverted, becomes the active-low load strobe shared by every slice. The next clock edge then loads a fixed start value (default 0xEA3) instead of wrapping to zero. The counter therefore runs a closed loop of 349 states.

The divided clock is bit 8 of the count, the lowest bit of the top slice. It comes straight from a flip-flop, so it can only change just after a rising clock edge. The block has no data stream, so every pin is a plain control or status signal.

Top module: `cdiv_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the count loads the start value 0xEA3, so `div_clk` and `term_cnt` are 0 after that edge.
- R2: Outside reset and reload, the count increases by exactly one on every rising clock edge.
- R3: A carry passes between slices only when the lower slices are all ones: 0xEAF steps to 0xEB0, and 0xEFF steps to 0xF00.
- R4: `term_cnt` is 1 exactly when the count is 0xFFF and is 0 for every other state.
- R5: On the edge after the count reaches 0xFFF, the count becomes 0xEA3 rather than 0x000.
- R6: `div_clk` always equals count bit 8. It is 0 for counts 0xEA3 through 0xEFF and 1 for counts 0xF00 through 0xFFF.
- R7: `div_clk` has a period of 349 input clocks. Within each period it is high for 256 clocks and low for 93 clocks.
- R8: `div_clk` changes only just after a rising clock edge and holds steady for the rest of the clock period.
- R9: A reset applied in the middle of a run returns the count to 0xEA3, and counting resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the start value |
| count | output | 12 | Current counter value |
| term_cnt | output | 1 | Carry-out of the top slice; high only at all ones |
| div_clk | output | 1 | Divided clock, count bit 8 |

## Verification
The hardest points to reach are the two slice-boundary carries and the 0xFFF-to-start reload. They occur only hundreds of clocks after reset, and they occur in a single cycle each. The directed tasks free-run the counter through full periods. Each task compares every cycle against a bench model and checks the exact steps at 0xEAF, 0xEFF and 0xFFF. A separate task asserts reset deep into the high phase to confirm that the count returns to the start value from an arbitrary point.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  parameter int unsigned SLICE_W = 4;
  parameter int unsigned SLICES  = 3;
  parameter int unsigned CNT_W   = SLICE_W * SLICES;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/cdiv_slice.sv
// One 4-bit counter slice. Load has priority over counting.
// The carry-out is formed from the carry-in and the all-ones state.
module cdiv_slice #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         carry_in,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q,
  output logic         carry_out
);
  always_ff @(posedge clk) begin
    if (rst || !load_n) begin
      q <= preset;
    end else if (cnt_en && carry_in) begin
      q <= q + 1'b1;
    end
  end

  assign carry_out = carry_in & (&q);
endmodule

// File: rtl/cdiv_reload.sv
// Builds the shared active-low load strobe from the top slice's carry-out.
module cdiv_reload (
  input  logic top_carry,
  output logic load_n
);
  assign load_n = ~top_carry;
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top #(
  parameter int unsigned             SLICE_W = cdiv_pkg::SLICE_W,
  parameter int unsigned             SLICES  = cdiv_pkg::SLICES,
  parameter int unsigned             CNT_W   = SLICE_W * SLICES,
  parameter logic [CNT_W-1:0]        PRELOAD = 12'hEA3,
  parameter int unsigned             TAP     = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count,
  output logic             term_cnt,
  output logic             div_clk
);
  logic [SLICES:0] chain;
  logic            load_n;

  assign chain[0] = 1'b1;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    cdiv_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .cnt_en   (1'b1),
      .carry_in (chain[i]),
      .load_n   (load_n),
      .preset   (PRELOAD[i*SLICE_W +: SLICE_W]),
      .q        (count[i*SLICE_W +: SLICE_W]),
      .carry_out(chain[i+1])
    );
  end

  cdiv_reload u_reload (
    .top_carry(chain[SLICES]),
    .load_n   (load_n)
  );

  assign term_cnt = chain[SLICES];
  assign div_clk  = count[TAP];
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
  parameter int unsigned      CNT_W   = 12,
  parameter logic [CNT_W-1:0] PRELOAD = 12'hEA3,
  parameter int unsigned      TAP     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic             term_cnt,
  input logic             div_clk
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_tc_at_full_R4: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (count == {CNT_W{1'b1}}));

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    term_cnt |=> (count == PRELOAD));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (count != PRELOAD) |-> (count == $past(count) + 1'b1));

  assert_tap_R6: assert property (@(posedge clk) disable iff (rst)
    div_clk == count[TAP]);

  assert_in_loop_R5: assert property (@(posedge clk) disable iff (rst)
    count >= PRELOAD);
endmodule

bind cdiv_top cdiv_checker #(.CNT_W(CNT_W), .PRELOAD(PRELOAD), .TAP(TAP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .count   (count),
  .term_cnt(term_cnt),
  .div_clk (div_clk)
);

// File: tb/cdiv_top_test.sv
module cdiv_top_test;
  localparam logic [11:0] START = 12'hEA3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] count;
  logic        term_cnt;
  logic        div_clk;
  int          vectors = 0;
  int          errs = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cdiv_top uut (.clk(clk), .rst(rst), .count(count), .term_cnt(term_cnt), .div_clk(div_clk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] nxt(input logic [11:0] c);
    return (c == 12'hFFF) ? START : c + 12'd1;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    step();
    chk(count == START, "R1 count", count, START);
    chk(div_clk == 1'b0, "R1 div_clk", div_clk, 0);
    chk(term_cnt == 1'b0, "R1 term_cnt", term_cnt, 0);
    rst = 1'b0;
  endtask

  // Two full periods compared cycle by cycle against the model.
  task automatic t_sequence();
    logic [11:0] exp = count;
    int bad = 0;
    for (int i = 0; i < 2 * 349; i++) begin
      logic [11:0] prev = count;
      step();
      exp = nxt(exp);
      if (count != exp) begin
        bad++;
        chk(1'b0, "R2 step", count, exp);
      end
      if (term_cnt != (count == 12'hFFF)) begin
        bad++;
        chk(1'b0, "R4 term_cnt", term_cnt, count == 12'hFFF);
      end
      if (div_clk != (count >= 12'hF00)) begin
        bad++;
        chk(1'b0, "R6 div_clk", div_clk, count >= 12'hF00);
      end
      if (prev == 12'hEAF) chk(count == 12'hEB0, "R3 carry EAF", count, 12'hEB0);
      if (prev == 12'hEFF) chk(count == 12'hF00, "R3 carry EFF", count, 12'hF00);
      if (prev == 12'hFFF) chk(count == START, "R5 reload", count, START);
    end
    chk(bad == 0, "R2 R4 R6 sequence", bad, 0);
  endtask

  // Measures the period and the high time of div_clk.
  task automatic t_period();
    int cyc = 0;
    int rise1 = -1;
    int rise2 = -1;
    int fall1 = -1;
    logic prev = div_clk;
    while (rise2 < 0 && cyc < 2000) begin
      step();
      cyc++;
      if (!prev && div_clk) begin
        if (rise1 < 0) rise1 = cyc; else rise2 = cyc;
      end
      if (prev && !div_clk && rise1 >= 0 && fall1 < 0) fall1 = cyc;
      prev = div_clk;
    end
    chk(rise2 - rise1 == 349, "R7 period", rise2 - rise1, 349);
    chk(fall1 - rise1 == 256, "R7 high time", fall1 - rise1, 256);
    chk(rise2 - fall1 == 93, "R7 low time", rise2 - fall1, 93);
  endtask

  // div_clk must hold between edges.
  task automatic t_glitch();
    int bad = 0;
    for (int i = 0; i < 400; i++) begin
      logic v;
      step();
      v = div_clk;
      #2; if (div_clk != v) bad++;
      #5; if (div_clk != v) bad++;
    end
    chk(bad == 0, "R8 stable between edges", bad, 0);
  endtask

  task automatic t_mid_reset();
    while (count != 12'hF40) step();
    chk(div_clk == 1'b1, "R6 high before mid reset", div_clk, 1);
    rst = 1'b1;
    step();
    chk(count == START, "R9 mid reset", count, START);
    chk(div_clk == 1'b0, "R9 div_clk after reset", div_clk, 0);
    rst = 1'b0;
    step();
    chk(count == START + 12'd1, "R9 resume", count, START + 12'd1);
  endtask

  initial begin
    #3;
    t_reset();
    t_sequence();
    t_period();
    t_glitch();
    t_mid_reset();
    t_sequence();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule